// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block sequences one programmed-I/O transfer on a legacy IDE drive bus. A host raises a request with a direction (read or write) and a drive number (0 or 1). The block accepts it when idle and runs three phases. The first is an address-setup phase with the drive selects active. The second is a command phase in which the active-low read or write strobe is driven. The third is a recovery phase that holds off the next transfer. The data path, DMA and ready-line stretching sit outside this block.

The phase lengths come from a small register file. Each drive has its own read-timing byte and its own write-timing byte. In each byte the high nibble is the command pulse width and the low nibble is the recovery time. A shared control register holds the address-setup field and a bank index. The index chooses which drive's timing bytes the register port reaches. A read-only strap bit reports whether the bus clock is the slow one or the fast one.

Each phase lasts its field value plus one clock. All timing is captured when a request is accepted, so software may reprogram the registers while a transfer is in flight without disturbing it.

Top module: `pio_cycle_timer`

## Requirements
- R1: Offset 0 reaches the read-timing byte and offset 1 reaches the write-timing byte of the bank chosen by control bit 0. Bank 0 belongs to drive 0 and bank 1 to drive 1. Writes store the full byte and reads return it.
- R2: The control register sits at offset 6. Bits 6:0 are writable and bit 7 always reads 0. Bit 0 is the bank index, bits 5:4 are the address-setup count, bits 3:1 are a delay field and bit 6 is a prefetch enable. The delay field and the prefetch enable are stored and read back only.
- R3: Offset 5 reads as seven zero bits above the strap input in bit 0, where 0 means a 33 MHz bus and 1 means a 25 MHz bus. Writes to offset 5 are ignored. Every other unused offset reads 0.
- R4: `req_ack` equals `req_valid` while `busy` is low; an acknowledged request raises `busy` on the next clock. `busy` stays high until the last recovery clock.
- R5: The setup phase lasts (bits 5:4 of the control register)+1 clocks. During it `cs_active` is high and both strobes are high.
- R6: The command phase lasts (high nibble of the requested drive's timing byte)+1 clocks, using the read byte for reads and the write byte for writes. `rd_n` is low for reads and `wr_n` is low for writes. The other strobe stays high, and `cs_active` stays high.
- R7: The recovery phase lasts (low nibble of the same timing byte)+1 clocks, with `cs_active` low and both strobes high.
- R8: `dev_sel` equals the requested drive throughout setup and command and does not change while `cs_active` is high.
- R9: A request still held when a transfer ends is not dropped. It is acknowledged in the single idle clock that follows recovery.
- R10: Timing is captured at acceptance. Register writes made after acceptance change only later transfers.
- R11: After reset, `busy` and `cs_active` are low, both strobes are high, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| clk_is_slow | input | 1 | Bus speed strap, 1 = 25 MHz |
| req_valid | input | 1 | Transfer request, held until acknowledged |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_drive | input | 1 | Target drive |
| req_ack | output | 1 | Request accepted this clock |
| busy | output | 1 | Transfer in progress |
| cs_active | output | 1 | Drive selects valid (setup and command phases) |
| dev_sel | output | 1 | Drive being addressed |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Directed transfers with all timing fields at zero check that each phase still lasts one clock. Directed transfers with the widest fields check that the counters reach their full length. Random programming of both banks, followed by random reads and writes to random drives, separates three things: the read byte from the write byte, drive 0's bank from drive 1's bank, and the pulse nibble from the recovery nibble. A bank index that differs from the requested drive shows that the transfer picks its bank by drive and not by index. A request held across a transfer shows that stalled requests are kept. A register rewrite during the setup phase shows that timing is captured at acceptance.

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       clk_is_slow,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_drive,
  output logic       req_ack,
  output logic       busy,
  output logic       cs_active,
  output logic       dev_sel,
  output logic       rd_n,
  output logic       wr_n
);
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE, S_RECOV} st_t;

  st_t        st;
  logic [3:0] cnt, l_pw, l_rt;
  logic       l_wr, l_drv;
  logic [7:0] trd [2];
  logic [7:0] twr [2];
  logic [6:0] ctl;
  logic [7:0] pick;

  assign busy      = (st != S_IDLE);
  assign req_ack   = req_valid && !busy;
  assign cs_active = (st == S_SETUP) || (st == S_PULSE);
  assign dev_sel   = l_drv;
  assign rd_n      = !((st == S_PULSE) && !l_wr);
  assign wr_n      = !((st == S_PULSE) && l_wr);
  assign pick      = req_write ? twr[req_drive] : trd[req_drive];

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = trd[ctl[0]];
      3'd1:    reg_rdata = twr[ctl[0]];
      3'd5:    reg_rdata = {7'b0, clk_is_slow};
      3'd6:    reg_rdata = {1'b0, ctl};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      l_pw  <= '0;
      l_rt  <= '0;
      l_wr  <= 1'b0;
      l_drv <= 1'b0;
      ctl   <= '0;
      for (int i = 0; i < 2; i++) begin
        trd[i] <= '0;
        twr[i] <= '0;
      end
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0:    trd[ctl[0]] <= reg_wdata;
          3'd1:    twr[ctl[0]] <= reg_wdata;
          3'd6:    ctl <= reg_wdata[6:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (req_valid) begin
          st    <= S_SETUP;
          cnt   <= {2'b0, ctl[5:4]};
          l_pw  <= pick[7:4];
          l_rt  <= pick[3:0];
          l_wr  <= req_write;
          l_drv <= req_drive;
        end
        S_SETUP: if (cnt == 0) begin
          st  <= S_PULSE;
          cnt <= l_pw;
        end else cnt <= cnt - 1'b1;
        S_PULSE: if (cnt == 0) begin
          st  <= S_RECOV;
          cnt <= l_rt;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == 0) st <= S_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ack,
  input logic busy,
  input logic cs_active,
  input logic dev_sel,
  input logic rd_n,
  input logic wr_n
);
  AST_ACK_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !busy);                                           // R4
  AST_ACK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> busy && cs_active);                               // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || wr_n);                                                // R6
  AST_STROBE_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> cs_active);                              // R6
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && $past(cs_active)) |-> $stable(dev_sel));        // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && !cs_active));                      // R11
  AST_STROBE_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> busy && !cs_active);         // R7
endmodule

bind pio_cycle_timer pio_cycle_timer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .busy(busy),
  .cs_active(cs_active), .dev_sel(dev_sel), .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/test_pio_cycle_timer.sv
`timescale 1ns/1ps
module test_pio_cycle_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, clk_is_slow = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic req_valid = 1'b0, req_write = 1'b0, req_drive = 1'b0;
  logic req_ack, busy, cs_active, dev_sel, rd_n, wr_n;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_rd [2];
  logic [7:0] m_wr [2];
  logic [6:0] m_ctl;

  always #2.5 clk = ~clk;

  pio_cycle_timer i_pio_cycle_timer (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    wrap_up();
  end

  function automatic void model_wr(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: m_rd[m_ctl[0]] = d;
      3'd1: m_wr[m_ctl[0]] = d;
      3'd6: m_ctl = d[6:0];
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_rd[m_ctl[0]];
      3'd1: return m_wr[m_ctl[0]];
      3'd5: return {7'b0, clk_is_slow};
      3'd6: return {1'b0, m_ctl};
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata === model_rd(a), tag, reg_rdata, model_rd(a));
  endtask

  // Measures a transfer already accepted; first sample is the first setup clock.
  task automatic measure(input bit w, input bit d, input bit pk,
                         input logic [2:0] pa, input logic [7:0] pd);
    logic [7:0] tb;
    int es, ep, er, sc, pc, rc, it;
    bit order_ok, strobe_ok, sel_ok;
    tb = w ? m_wr[d] : m_rd[d];
    es = int'(m_ctl[5:4]) + 1; ep = int'(tb[7:4]) + 1; er = int'(tb[3:0]) + 1;
    sc = 0; pc = 0; rc = 0; it = 0;
    order_ok = 1; strobe_ok = 1; sel_ok = 1;
    while (busy && it < 80) begin
      if (pk && it == 0) begin reg_we = 1'b1; reg_addr = pa; reg_wdata = pd; end
      if (pk && it == 1) begin reg_we = 1'b0; model_wr(pa, pd); end
      if (cs_active && rd_n && wr_n) begin
        if (pc > 0 || rc > 0) order_ok = 0;
        sc++;
      end else if (cs_active) begin
        if (rc > 0) order_ok = 0;
        if (w ? (wr_n || !rd_n) : (rd_n || !wr_n)) strobe_ok = 0;
        pc++;
      end else begin
        if (!rd_n || !wr_n) strobe_ok = 0;
        rc++;
      end
      if (cs_active && dev_sel !== d) sel_ok = 0;
      it++;
      @(negedge clk);
    end
    if (pk && it == 1) begin reg_we = 1'b0; model_wr(pa, pd); end
    chk(sc == es, "R5 setup length", sc, es);
    chk(pc == ep, "R6 pulse length", pc, ep);
    chk(strobe_ok && order_ok, "R6 strobe choice/order", strobe_ok, 1);
    chk(rc == er, "R7 recovery length", rc, er);
    chk(sel_ok, "R8 drive select", sel_ok, 1);
  endtask

  task automatic xfer(input bit w, input bit d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_drive = d;
    #1;
    chk(req_ack === !busy, "R4 ack when idle", req_ack, !busy);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R4 busy after ack", busy, 1);
    measure(w, d, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    void'($urandom(32'h1DE5));
    m_rd[0] = 0; m_rd[1] = 0; m_wr[0] = 0; m_wr[1] = 0; m_ctl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(busy === 0 && cs_active === 0, "R11 idle after reset", busy, 0);
    chk(rd_n === 1 && wr_n === 1, "R11 strobes high", {rd_n, wr_n}, 3);
    rd_chk(3'd0, "R11 read timing zero");
    rd_chk(3'd6, "R11 control zero");
    // R3 strap and unused offsets
    rd_chk(3'd5, "R3 strap 33 MHz");
    clk_is_slow = 1'b1;
    rd_chk(3'd5, "R3 strap 25 MHz");
    wr_reg(3'd5, 8'hFF);
    rd_chk(3'd5, "R3 strap write ignored");
    wr_reg(3'd3, 8'hAA);
    rd_chk(3'd3, "R3 unused offset zero");
    // R2 control mask
    wr_reg(3'd6, 8'hFF);
    rd_chk(3'd6, "R2 bit7 masked");
    wr_reg(3'd6, 8'h0E);
    rd_chk(3'd6, "R2 delay field stored");
    // R1 banks
    wr_reg(3'd0, 8'h12); wr_reg(3'd1, 8'h34);
    wr_reg(3'd6, 8'h01);
    wr_reg(3'd0, 8'h56); wr_reg(3'd1, 8'h78);
    rd_chk(3'd0, "R1 bank1 read byte");
    wr_reg(3'd6, 8'h00);
    rd_chk(3'd1, "R1 bank0 write byte");
    // minimum fields
    wr_reg(3'd0, 8'h00); wr_reg(3'd1, 8'h00);
    xfer(1'b0, 1'b0);
    xfer(1'b1, 1'b0);
    // maximum fields, index pointing at drive 0, transfer on drive 1
    wr_reg(3'd6, 8'h31);
    wr_reg(3'd0, 8'hFF); wr_reg(3'd1, 8'hF0);
    wr_reg(3'd6, 8'h30);
    xfer(1'b0, 1'b1);
    xfer(1'b1, 1'b1);
    // R9 held request across a transfer
    wr_reg(3'd6, 8'h10);
    wr_reg(3'd0, 8'h21);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_drive = 1'b0;
    @(negedge clk);
    measure(1'b0, 1'b0, 1'b0, 3'd0, 8'h00);
    #1;
    chk(req_ack === 1'b1 && busy === 1'b0, "R9 held request acked in idle clock", req_ack, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 second transfer started", busy, 1);
    measure(1'b0, 1'b0, 1'b0, 3'd0, 8'h00);
    // R10 register rewrite during setup
    wr_reg(3'd6, 8'h20);
    wr_reg(3'd1, 8'h32);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_drive = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    measure(1'b1, 1'b0, 1'b1, 3'd1, 8'hA9);
    rd_chk(3'd1, "R10 rewrite landed after cycle");
    xfer(1'b1, 1'b0);
    // random
    for (int k = 0; k < 40; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      wr_reg(3'd6, {1'b0, r[6:1], 1'b0});
      wr_reg(3'd0, 8'($urandom)); wr_reg(3'd1, 8'($urandom));
      wr_reg(3'd6, {1'b0, r[6:1], 1'b1});
      wr_reg(3'd0, 8'($urandom)); wr_reg(3'd1, 8'($urandom));
      wr_reg(3'd6, {1'b0, r[6:1], r[0]});
      rd_chk(3'($urandom_range(0, 1)), "R1 random readback");
      xfer(1'($urandom), 1'($urandom));
    end
    wrap_up();
  end
endmodule